// File: doc/BRIEF.md
# Flash Reset and Power-Down Sequencer

This block watches the active-low hardware reset pin of a flash memory from inside the memory's own synchronous logic. It measures every low pulse on the pin against a minimum width given in clock cycles. A pulse that is too short is thrown away and changes nothing. A pulse that meets the width is accepted and the block does the following:
- It stops any program or erase that is running, and marks the stored data as possibly damaged.
- It clears the status register.
- It puts the device into deep power-down.
- It holds the command logic in reset and keeps the data bus at high impedance for as long as the pin stays low.

When the pin goes high again, a single recovery counter starts. Bus reads are allowed once the counter passes the read-recovery threshold, and bus writes once it passes the separate write-recovery threshold. The device then runs in its default asynchronous random-read mode.

The pin passes through a configurable synchronizer before use. A width parameter caps the pulse and recovery counters. An elaboration-time bound makes sure the abort is raised within a fixed number of cycles after the pin falls.

Top module: `flash_rst_seq`

## Requirements
- R1: A low level on `rst_pin_n` seen on at least `T_PULSE` consecutive synchronized samples is accepted. `pd_flag` rises `SYNC_STAGES + T_PULSE` clock edges after the first edge at which the pin is low.
- R2: A low pulse shorter than `T_PULSE` samples has no effect. `pd_flag`, `pe_abort`, `status_clr` and `force_hiz` stay low, `rd_ready` and `wr_ready` stay high, and `data_suspect` is unchanged.
- R3: When a reset is accepted while `pe_busy` is high, `pe_abort` is high for exactly one cycle. That cycle is the first cycle of `pd_flag`, and it lies no more than `ABORT_MAX` edges after the pin falls.
- R4: On every accepted reset, `status_clr` pulses for one cycle, in the first cycle of `pd_flag`. `pe_abort` stays low if `pe_busy` was low.
- R5: While powered down, `pd_flag`, `force_hiz` and `ctl_reset` are high, and `rd_ready` and `wr_ready` are low.
- R6: After the pin returns high, `rd_ready` rises `SYNC_STAGES + T_READ + 1` edges after the first edge at which the pin is high. `force_hiz` falls in the same cycle.
- R7: `wr_ready` rises `SYNC_STAGES + T_WRITE + 1` edges after the first edge at which the pin is high. It is never high while `rd_ready` is low.
- R8: On each accepted reset, `data_suspect` takes the value of `pe_busy`. It is set together with an abort and cleared by an accepted reset that finds no operation running.
- R9: If the pin falls again during recovery, the block returns to power-down at once. It gives no abort and no status-clear pulse, and the recovery count restarts from the next rise.
- R10: When recovery ends, `rd_ready` and `wr_ready` are high and `force_hiz` and `ctl_reset` are low, which is normal asynchronous read operation.
- R11: After system reset, `rd_ready` and `wr_ready` are high and every other output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| rst_pin_n | input | 1 | Asynchronous active-low reset / power-down pin |
| pe_busy | input | 1 | A program, erase or protection program is running |
| pe_abort | output | 1 | One-cycle abort request to the program/erase controller |
| status_clr | output | 1 | One-cycle status register clear |
| pd_flag | output | 1 | Deep power-down active |
| force_hiz | output | 1 | Force the data bus to high impedance |
| ctl_reset | output | 1 | Hold the command interface and program/erase controller in reset |
| rd_ready | output | 1 | Bus reads allowed |
| wr_ready | output | 1 | Bus writes allowed |
| data_suspect | output | 1 | The last accepted reset aborted an operation, so data may be corrupt |

## Verification
Low pulses of 1, 3 and 5 cycles sit below the 6-sample threshold. Pulses of 6, 7, 9 and 12 cycles sit at or above it. Together they place the accept/reject boundary exactly at `T_PULSE` and show that acceptance timing does not depend on pulse length. Some pulses come with `pe_busy` high and some with it low, which separates the abort pulse from the status clear and drives `data_suspect` both up and down. A fall of the pin during recovery shows that recovery restarts without a second abort or status clear. Exact rise cycles of `rd_ready` and `wr_ready` show that the two thresholds are taken from the single shared counter independently.

// File: rtl/frs_pkg.sv
package frs_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_PCHK  = 2'd1,
      ST_PDOWN = 2'd2,
      ST_RECOV = 2'd3
   } frs_state_e;
endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;      // idle pin level is high
            else if (STAGES == 1) sh <= din;
            else sh <= {sh[STAGES-2:0], din};
         end
         assign dout = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/frs_core.sv
module frs_core
   import frs_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int T_PULSE = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_lo,
   input  logic       pe_busy,
   input  logic       rec_done,
   output frs_state_e state,
   output frs_state_e nxt,
   output logic       abort_q,
   output logic       clr_q,
   output logic       suspect_q
);
   localparam logic [CNT_W-1:0] PULSE_LIM = CNT_W'(T_PULSE);
   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

   logic [CNT_W-1:0] pc;
   logic [CNT_W-1:0] pc_inc;
   logic             accept;

   assign pc_inc = pc + ONE;

   always_comb begin
      nxt    = state;
      accept = 1'b0;
      unique case (state)
         ST_RUN:   if (pin_lo) nxt = ST_PCHK;
         ST_PCHK: begin
            if (!pin_lo) nxt = ST_RUN;
            else if (pc_inc >= PULSE_LIM) begin
               nxt    = ST_PDOWN;
               accept = 1'b1;
            end
         end
         ST_PDOWN: if (!pin_lo) nxt = ST_RECOV;
         ST_RECOV: begin
            if (pin_lo) nxt = ST_PDOWN;          // silent re-entry
            else if (rec_done) nxt = ST_RUN;
         end
         default:  nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_RUN;
         pc        <= '0;
         abort_q   <= 1'b0;
         clr_q     <= 1'b0;
         suspect_q <= 1'b0;
      end else begin
         state   <= nxt;
         abort_q <= accept & pe_busy;
         clr_q   <= accept;
         if (accept) suspect_q <= pe_busy;
         if (nxt == ST_PCHK) pc <= (state == ST_PCHK) ? pc_inc : ONE;
         else pc <= '0;
      end
   end
endmodule

// File: rtl/frs_recov.sv
module frs_recov
   import frs_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int T_READ  = 10,
   parameter int T_WRITE = 17
) (
   input  logic       clk,
   input  logic       rst_n,
   input  frs_state_e state,
   input  frs_state_e nxt,
   output logic       rec_done,
   output logic       rd_q,
   output logic       wr_q,
   output logic       hiz_q
);
   localparam int               T_MAX  = (T_READ > T_WRITE) ? T_READ : T_WRITE;
   localparam logic [CNT_W-1:0] RD_LIM = CNT_W'(T_READ);
   localparam logic [CNT_W-1:0] WR_LIM = CNT_W'(T_WRITE);
   localparam logic [CNT_W-1:0] MX_LIM = CNT_W'(T_MAX);

   logic [CNT_W-1:0] rc, rc_inc, rc_n;
   logic             rd_n, wr_n, hiz_n, in_run;

   assign rc_inc   = rc + CNT_W'(1);
   assign rec_done = (state == ST_RECOV) && (rc_inc >= MX_LIM);

   always_comb begin
      rc_n   = ((nxt == ST_RECOV) && (state == ST_RECOV)) ? rc_inc : '0;
      in_run = (nxt == ST_RUN) || (nxt == ST_PCHK);
      rd_n   = in_run || ((nxt == ST_RECOV) && (rc_n >= RD_LIM));
      wr_n   = in_run || ((nxt == ST_RECOV) && (rc_n >= WR_LIM));
      hiz_n  = (nxt == ST_PDOWN) || ((nxt == ST_RECOV) && !rd_n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rc    <= '0;
         rd_q  <= 1'b1;
         wr_q  <= 1'b1;
         hiz_q <= 1'b0;
      end else begin
         rc    <= rc_n;
         rd_q  <= rd_n;
         wr_q  <= wr_n;
         hiz_q <= hiz_n;
      end
   end
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
   import frs_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int T_PULSE     = 6,
   parameter int T_READ      = 10,
   parameter int T_WRITE     = 17,
   parameter int ABORT_MAX   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_pin_n,
   input  logic pe_busy,
   output logic pe_abort,
   output logic status_clr,
   output logic pd_flag,
   output logic force_hiz,
   output logic ctl_reset,
   output logic rd_ready,
   output logic wr_ready,
   output logic data_suspect
);
   localparam int T_MAX = (T_READ > T_WRITE) ? T_READ : T_WRITE;

   generate
      if (T_PULSE < 2) begin : g_chk_pulse
         $error("T_PULSE must be at least 2");
      end
      if (T_READ < 1 || T_WRITE < 1) begin : g_chk_rec
         $error("recovery delays must be at least 1");
      end
      if (T_MAX >= (1 << CNT_W) || T_PULSE >= (1 << CNT_W)) begin : g_chk_w
         $error("CNT_W too narrow for the cycle counts");
      end
      if (SYNC_STAGES + T_PULSE + 1 > ABORT_MAX) begin : g_chk_ab
         $error("abort latency exceeds ABORT_MAX");
      end
   endgenerate

   logic       pin_s;
   logic       rec_done;
   frs_state_e state, nxt;

   frs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rst_pin_n), .dout(pin_s)
   );

   frs_core #(.CNT_W(CNT_W), .T_PULSE(T_PULSE)) u_core (
      .clk(clk), .rst_n(rst_n), .pin_lo(!pin_s), .pe_busy(pe_busy),
      .rec_done(rec_done), .state(state), .nxt(nxt),
      .abort_q(pe_abort), .clr_q(status_clr), .suspect_q(data_suspect)
   );

   frs_recov #(.CNT_W(CNT_W), .T_READ(T_READ), .T_WRITE(T_WRITE)) u_recov (
      .clk(clk), .rst_n(rst_n), .state(state), .nxt(nxt),
      .rec_done(rec_done), .rd_q(rd_ready), .wr_q(wr_ready), .hiz_q(force_hiz)
   );

   assign pd_flag   = (state == ST_PDOWN);
   assign ctl_reset = (state == ST_PDOWN);
endmodule

// File: rtl/flash_rst_seq_chk.sv
module flash_rst_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic pe_abort,
   input logic status_clr,
   input logic pd_flag,
   input logic force_hiz,
   input logic ctl_reset,
   input logic rd_ready,
   input logic wr_ready,
   input logic data_suspect
);
   a_r3_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      pe_abort |=> !pe_abort);
   a_r3_abort_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
      pe_abort |-> (status_clr && $rose(pd_flag)));
   a_r4_clr_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
      status_clr |-> $rose(pd_flag));
   a_r5_pd_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      pd_flag |-> (force_hiz && ctl_reset && !rd_ready && !wr_ready));
   a_r6_hiz_vs_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |-> !force_hiz);
   a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> rd_ready);
   a_r8_suspect_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_suspect) |-> pe_abort);
endmodule

bind flash_rst_seq flash_rst_seq_chk u_chk (.*);

// File: tb/flash_rst_seq_test.sv
`timescale 1ns/1ps
module flash_rst_seq_test;
   localparam int SYNC = 2, TP = 6, TR = 10, TW = 17;
   localparam int NV = 7;
   localparam int V_LOW [NV] = '{1, 3, 5, 6, 7, 9, 12};
   localparam bit V_BUSY[NV] = '{1, 0, 1, 1, 0, 0, 1};
   localparam bit V_ACC [NV] = '{0, 0, 0, 1, 1, 1, 1};

   logic clk = 1'b0, rst_n = 1'b0, rst_pin_n = 1'b1, pe_busy = 1'b0;
   logic pe_abort, status_clr, pd_flag, force_hiz, ctl_reset;
   logic rd_ready, wr_ready, data_suspect;

   always #2.5 clk = ~clk;

   flash_rst_seq uut (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   int idx, ab_cnt, clr_cnt, pd_first, rd_rise, wr_rise;
   bit rd_low_seen, hiz_seen, pd_ok;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clr_obs();
      idx = 0; ab_cnt = 0; clr_cnt = 0; pd_first = -1; rd_rise = -1; wr_rise = -1;
      rd_low_seen = 0; hiz_seen = 0; pd_ok = 0;
   endtask

   task automatic sample(input int k);
      idx++;
      if (pe_abort) ab_cnt++;
      if (status_clr) clr_cnt++;
      if (force_hiz) hiz_seen = 1;
      if (pd_flag && pd_first < 0) begin
         pd_first = idx;
         pd_ok = force_hiz && ctl_reset && !rd_ready && !wr_ready;
      end
      if (!rd_ready) rd_low_seen = 1;
      if (k > 0 && rd_ready && rd_low_seen && rd_rise < 0) rd_rise = k;
      if (k > 0 && wr_ready && rd_low_seen && wr_rise < 0) wr_rise = k;
   endtask

   // drive a low pulse of nlow cycles, then watch 40 cycles of recovery
   task automatic pulse(input int nlow, input bit busy);
      clr_obs();
      @(negedge clk);
      rst_pin_n = 1'b0;
      pe_busy   = busy;
      for (int i = 0; i < nlow; i++) begin
         @(negedge clk);
         sample(0);
      end
      rst_pin_n = 1'b1;
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         sample(k);
      end
      pe_busy = 1'b0;
   endtask

   initial begin
      bit exp_sus;
      exp_sus = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: state after system reset
      chk(rd_ready && wr_ready, "R11", "ready flags", {rd_ready, wr_ready}, 3);
      chk(!pd_flag && !force_hiz && !ctl_reset && !pe_abort && !status_clr && !data_suspect,
          "R11", "other outputs", {pd_flag, force_hiz, ctl_reset, pe_abort, status_clr, data_suspect}, 0);

      for (int v = 0; v < NV; v++) begin
         pulse(V_LOW[v], V_BUSY[v]);
         if (!V_ACC[v]) begin
            // R2: runt pulse ignored
            chk(pd_first < 0, "R2", "pd_flag seen", pd_first, -1);
            chk(ab_cnt == 0 && clr_cnt == 0, "R2", "pulses", ab_cnt + clr_cnt, 0);
            chk(!rd_low_seen && !hiz_seen, "R2", "ready/hiz disturbed", {rd_low_seen, hiz_seen}, 0);
            chk(data_suspect == exp_sus, "R2", "data_suspect", data_suspect, exp_sus);
         end else begin
            exp_sus = V_BUSY[v];
            chk(pd_first == SYNC + TP, "R1", "pd_flag first cycle", pd_first, SYNC + TP);
            chk(pd_ok, "R5", "outputs in power-down", pd_ok, 1);
            chk(ab_cnt == int'(V_BUSY[v]), "R3", "abort count", ab_cnt, V_BUSY[v]);
            chk(clr_cnt == 1, "R4", "status clear count", clr_cnt, 1);
            chk(rd_rise == SYNC + TR + 1, "R6", "read ready cycle", rd_rise, SYNC + TR + 1);
            chk(wr_rise == SYNC + TW + 1, "R7", "write ready cycle", wr_rise, SYNC + TW + 1);
            chk(data_suspect == exp_sus, "R8", "data_suspect", data_suspect, exp_sus);
            chk(rd_ready && wr_ready && !force_hiz && !ctl_reset && !pd_flag, "R10",
                "end of recovery", {rd_ready, wr_ready, force_hiz, ctl_reset, pd_flag}, 5'b11000);
         end
      end

      // R9: pin falls again during recovery
      clr_obs();
      @(negedge clk);
      rst_pin_n = 1'b0;
      pe_busy   = 1'b1;
      for (int i = 0; i < 8; i++) begin @(negedge clk); sample(0); end
      pe_busy   = 1'b0;
      rst_pin_n = 1'b1;
      for (int i = 0; i < 5; i++) begin @(negedge clk); sample(0); end
      chk(!pd_flag && !rd_ready, "R9", "in recovery before refall", {pd_flag, rd_ready}, 0);
      ab_cnt = 0; clr_cnt = 0;
      rst_pin_n = 1'b0;
      pe_busy   = 1'b1;
      for (int i = 0; i < 2; i++) begin @(negedge clk); sample(0); end
      rst_pin_n = 1'b1;
      @(negedge clk); sample(0);
      chk(pd_flag == 1'b1, "R9", "back in power-down", pd_flag, 1);
      rd_rise = -1; wr_rise = -1;
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         sample(k + 1);
      end
      pe_busy = 1'b0;
      chk(ab_cnt == 0 && clr_cnt == 0, "R9", "pulses on refall", ab_cnt + clr_cnt, 0);
      chk(rd_rise == SYNC + TR + 1, "R9", "read ready after restart", rd_rise, SYNC + TR + 1);
      chk(wr_rise == SYNC + TW + 1, "R9", "write ready after restart", wr_rise, SYNC + TW + 1);
      chk(data_suspect == 1'b1, "R8", "suspect kept from abort", data_suspect, 1);

      // R8: clean accepted reset clears the suspect flag
      pulse(TP, 1'b0);
      chk(data_suspect == 1'b0, "R8", "suspect cleared", data_suspect, 0);
      chk(ab_cnt == 0 && clr_cnt == 1, "R4", "idle reset pulses", ab_cnt * 10 + clr_cnt, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule